// File: doc/BRIEF.md
# Pause Frame Flow-Control Requester

This block decides when a MAC transmitter should send a full-duplex flow-control pause frame, and which pause time the frame carries. It watches the free space left in the receive buffer. When free space drops below a high-water mark, it asks for a pause with the maximum time, FFFFh. Once that frame has gone out and free space has recovered past a low-water mark, it asks for a resume pause with time 0000h. Software can also force either kind of frame through two self-clearing command bits.

The block holds one request at a time and keeps the request and its pause time steady until the transmitter pulses `tx_done`. The frame builder, CRC logic and transmit path sit outside this block. The block only supplies the request and the 16-bit pause time.

The block holds an 8-bit threshold register and a 3-bit control register. Both are written through simple write strobes and read back on dedicated outputs, so software can see the force bits clear themselves.

Top module: `pfc_requester`

## Requirements
- R1: In the threshold register, bits 7:4 hold the high-water mark and bits 3:0 hold the low-water mark. Both count free space in units of 1024 bytes, and `thr_rdata` returns the stored value.
- R2: With auto mode enabled and no resume armed, free space strictly below high-water × 1024 raises a request with `pause_time` = FFFFh. Free space equal to that value raises nothing.
- R3: A resume request (`pause_time` = 0000h) is raised only when the resume is armed and free space is strictly greater than low-water × 1024. Only a completed automatic FFFFh frame arms the resume; a forced frame does not.
- R4: A high-water mark of 0 means "no free space": the automatic FFFFh request fires only when `free_bytes` equals 0.
- R5: After reset, the threshold register reads 8'h38 (high 3, low 8), the control register reads 0, and `pause_req` is low.
- R6: Control bit 2 forces a 0000h pause and control bit 1 forces an FFFFh pause. Each bit reads back as set until `tx_done` completes its own frame, and then clears.
- R7: Control bit 0 enables automatic requests. While it is 0, free-space conditions raise no request.
- R8: Only one request is outstanding at a time. `pause_req` and `pause_time` stay stable until `tx_done`. The request drops in the cycle after `tx_done`, and a new request can appear no earlier than one cycle after that.
- R9: A sustained low-space condition produces exactly one automatic FFFFh frame until a resume frame has been sent.
- R10: When both force bits are set, the FFFFh frame is requested first and the 0000h frame follows.
- R11: Forced requests win over automatic ones when both are pending while idle.
- R12: Clearing auto enable drops an armed resume, so no 0000h frame follows that earlier high-water frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| free_bytes | input | FREE_W | Free bytes in the receive buffer |
| thr_we | input | 1 | Threshold register write strobe |
| thr_wdata | input | 8 | Threshold write data (7:4 high, 3:0 low) |
| thr_rdata | output | 8 | Threshold register readback |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data (2 force zero, 1 force max, 0 auto) |
| ctl_rdata | output | 3 | Control register readback |
| tx_done | input | 1 | Pulse: the requested pause frame has been sent |
| pause_req | output | 1 | Pause frame request |
| pause_time | output | 16 | Pause time for the requested frame |

## Verification
The embedded assertions check the following on every cycle:
- the request and its pause time hold until completion;
- every pause time is one of the two legal codes;
- the resume arms only after a completed automatic maximum frame;
- a resume is never issued unarmed;
- the force bits clear after their own frame;
- the disarm on auto-disable;
- the zero high-water mark.

Boundary thresholds, priority ordering between forced and automatic frames, the single-frame behaviour under sustained low space, and the loss of an armed resume across an auto-disable only show up in the bench's scenarios. The bench compares those scenarios every clock against a behavioural model.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int KB_SHIFT = 10;
    localparam int CTL_W = 3;
    localparam int CTL_AUTO = 0;
    localparam int CTL_FMAX = 1;
    localparam int CTL_FZERO = 2;
    localparam logic [3:0] HW_RST = 4'd3;
    localparam logic [3:0] LW_RST = 4'd8;
    localparam logic [15:0] PTIME_MAX = 16'hFFFF;
    localparam logic [15:0] PTIME_ZERO = 16'h0000;

    typedef enum logic [1:0] {
        SRC_FMAX  = 2'd0,
        SRC_FZERO = 2'd1,
        SRC_AMAX  = 2'd2,
        SRC_AZERO = 2'd3
    } src_e;

    typedef struct packed {
        logic [3:0]       hw;
        logic [3:0]       lw;
        logic [CTL_W-1:0] ctl;
    } cfg_t;

    typedef struct packed {
        logic        busy;
        logic [15:0] ptime;
        src_e        src;
        logic        armed;
    } req_t;
endpackage

// File: rtl/pfc_cfg_regs.sv
module pfc_cfg_regs
    import pfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_we,
    input  logic [7:0]       thr_wdata,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             clr_fmax,
    input  logic             clr_fzero,
    output logic [3:0]       hw_kb,
    output logic [3:0]       lw_kb,
    output logic             force_max,
    output logic             force_zero,
    output logic             auto_en,
    output logic [7:0]       thr_rdata,
    output logic [CTL_W-1:0] ctl_rdata
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (clr_fmax)  cfg_d.ctl[CTL_FMAX]  = 1'b0;
        if (clr_fzero) cfg_d.ctl[CTL_FZERO] = 1'b0;
        if (ctl_we)    cfg_d.ctl = ctl_wdata;
        if (thr_we) begin
            cfg_d.hw = thr_wdata[7:4];
            cfg_d.lw = thr_wdata[3:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '{hw: HW_RST, lw: LW_RST, ctl: '0};
        else        cfg_q <= cfg_d;
    end

    assign hw_kb      = cfg_q.hw;
    assign lw_kb      = cfg_q.lw;
    assign force_max  = cfg_q.ctl[CTL_FMAX];
    assign force_zero = cfg_q.ctl[CTL_FZERO];
    assign auto_en    = cfg_q.ctl[CTL_AUTO];
    assign thr_rdata  = {cfg_q.hw, cfg_q.lw};
    assign ctl_rdata  = cfg_q.ctl;

    AST_FMAX_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fmax && !ctl_we) |=> !ctl_rdata[CTL_FMAX]);   // R6
    AST_FZERO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fzero && !ctl_we) |=> !ctl_rdata[CTL_FZERO]); // R6
endmodule

// File: rtl/pfc_level_mon.sv
module pfc_level_mon
    import pfc_pkg::*;
#(
    parameter int FREE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREE_W-1:0] free_bytes,
    input  logic [3:0]        hw_kb,
    input  logic [3:0]        lw_kb,
    output logic              space_low,
    output logic              space_high
);
    localparam int MARK_W = 4 + KB_SHIFT;

    logic [FREE_W-1:0] hw_bytes;
    logic [FREE_W-1:0] lw_bytes;

    always_comb begin
        hw_bytes = FREE_W'({hw_kb, {KB_SHIFT{1'b0}}});
        lw_bytes = FREE_W'({lw_kb, {KB_SHIFT{1'b0}}});
        if (hw_kb == 4'd0) space_low = (free_bytes == '0);
        else               space_low = (free_bytes < hw_bytes);
        space_high = (free_bytes > lw_bytes);
    end

    initial begin
        AST_FREE_WIDTH: assert (FREE_W >= MARK_W);             // R1
    end

    AST_ZERO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_kb == 4'd0 && free_bytes != '0) |-> !space_low);   // R4
endmodule

// File: rtl/pfc_req_fsm.sv
module pfc_req_fsm
    import pfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        force_max,
    input  logic        force_zero,
    input  logic        auto_en,
    input  logic        space_low,
    input  logic        space_high,
    input  logic        tx_done,
    output logic        pause_req,
    output logic [15:0] pause_time,
    output logic        clr_fmax,
    output logic        clr_fzero
);
    req_t st_d, st_q;
    logic done;

    always_comb begin
        st_d      = st_q;
        done      = st_q.busy && tx_done;
        clr_fmax  = done && (st_q.src == SRC_FMAX);
        clr_fzero = done && (st_q.src == SRC_FZERO);

        if (!auto_en)                            st_d.armed = 1'b0;
        else if (done && st_q.src == SRC_AMAX)   st_d.armed = 1'b1;
        else if (done && st_q.src == SRC_AZERO)  st_d.armed = 1'b0;

        if (st_q.busy) begin
            if (done) st_d.busy = 1'b0;
        end else if (force_max) begin
            st_d.busy = 1'b1; st_d.ptime = PTIME_MAX;  st_d.src = SRC_FMAX;
        end else if (force_zero) begin
            st_d.busy = 1'b1; st_d.ptime = PTIME_ZERO; st_d.src = SRC_FZERO;
        end else if (auto_en && !st_q.armed && space_low) begin
            st_d.busy = 1'b1; st_d.ptime = PTIME_MAX;  st_d.src = SRC_AMAX;
        end else if (auto_en && st_q.armed && space_high) begin
            st_d.busy = 1'b1; st_d.ptime = PTIME_ZERO; st_d.src = SRC_AZERO;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{busy: 1'b0, ptime: PTIME_ZERO, src: SRC_FMAX, armed: 1'b0};
        else        st_q <= st_d;
    end

    assign pause_req  = st_q.busy;
    assign pause_time = st_q.ptime;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && !tx_done) |=> (pause_req && $stable(pause_time)));        // R8
    AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && tx_done) |=> !pause_req);                                  // R8
    AST_LEGAL_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> (pause_time == PTIME_MAX || pause_time == PTIME_ZERO));    // R2
    AST_ARM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.armed) |-> $past(tx_done && st_q.busy && st_q.src == SRC_AMAX)); // R3
    AST_RESUME_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pause_req) && st_q.src == SRC_AZERO) |-> $past(st_q.armed));      // R3
    AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> !st_q.armed);                                               // R12
endmodule

// File: rtl/pfc_requester.sv
module pfc_requester
    import pfc_pkg::*;
#(
    parameter int FREE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREE_W-1:0] free_bytes,
    input  logic              thr_we,
    input  logic [7:0]        thr_wdata,
    output logic [7:0]        thr_rdata,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              tx_done,
    output logic              pause_req,
    output logic [15:0]       pause_time
);
    logic [3:0] hw_kb, lw_kb;
    logic       force_max, force_zero, auto_en;
    logic       space_low, space_high;
    logic       clr_fmax, clr_fzero;

    pfc_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n),
        .thr_we(thr_we), .thr_wdata(thr_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .clr_fmax(clr_fmax), .clr_fzero(clr_fzero),
        .hw_kb(hw_kb), .lw_kb(lw_kb),
        .force_max(force_max), .force_zero(force_zero), .auto_en(auto_en),
        .thr_rdata(thr_rdata), .ctl_rdata(ctl_rdata)
    );

    pfc_level_mon #(.FREE_W(FREE_W)) u_mon (
        .clk(clk), .rst_n(rst_n),
        .free_bytes(free_bytes), .hw_kb(hw_kb), .lw_kb(lw_kb),
        .space_low(space_low), .space_high(space_high)
    );

    pfc_req_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .force_max(force_max), .force_zero(force_zero), .auto_en(auto_en),
        .space_low(space_low), .space_high(space_high),
        .tx_done(tx_done),
        .pause_req(pause_req), .pause_time(pause_time),
        .clr_fmax(clr_fmax), .clr_fzero(clr_fzero)
    );
endmodule

// File: tb/pfc_requester_test.sv
`timescale 1ns/1ps
module pfc_requester_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] free_bytes = 16'd20000;
    logic        thr_we = 1'b0;
    logic [7:0]  thr_wdata = 8'h00;
    logic [7:0]  thr_rdata;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_wdata = 3'b000;
    logic [2:0]  ctl_rdata;
    logic        tx_done = 1'b0;
    logic        pause_req;
    logic [15:0] pause_time;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pfc_requester uut (
        .clk(clk), .rst_n(rst_n), .free_bytes(free_bytes),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .thr_rdata(thr_rdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .tx_done(tx_done), .pause_req(pause_req), .pause_time(pause_time)
    );

    // Behavioural reference: 0 = none, 1 = forced max, 2 = forced zero, 3 = auto max, 4 = auto zero
    int m_busy = 0, m_time = 0, m_src = 0, m_armed = 0, m_ctl = 0, m_thr = 'h38;

    always @(posedge clk) begin
        int hw, lw, nctl, nthr, narm, nbusy, ntime, nsrc;
        bit low, high, done;
        if (!rst_n) begin
            m_busy = 0; m_time = 0; m_src = 0; m_armed = 0; m_ctl = 0; m_thr = 'h38;
        end else begin
            hw = m_thr / 16; lw = m_thr % 16;
            low  = (hw == 0) ? (free_bytes == 0) : (int'(free_bytes) < hw * 1024);
            high = int'(free_bytes) > lw * 1024;
            done = tx_done && (m_busy != 0);
            nctl = m_ctl; narm = m_armed; nbusy = m_busy; ntime = m_time; nsrc = m_src;
            if (done && m_src == 1) nctl = nctl & 5;
            if (done && m_src == 2) nctl = nctl & 3;
            if (ctl_we) nctl = ctl_wdata;
            nthr = thr_we ? thr_wdata : m_thr;
            if ((m_ctl & 1) == 0) narm = 0;
            else if (done && m_src == 3) narm = 1;
            else if (done && m_src == 4) narm = 0;
            if (m_busy != 0) begin
                if (done) nbusy = 0;
            end else if ((m_ctl & 2) != 0) begin nbusy = 1; ntime = 'hFFFF; nsrc = 1; end
            else if ((m_ctl & 4) != 0) begin nbusy = 1; ntime = 0; nsrc = 2; end
            else if ((m_ctl & 1) != 0 && m_armed == 0 && low) begin nbusy = 1; ntime = 'hFFFF; nsrc = 3; end
            else if ((m_ctl & 1) != 0 && m_armed != 0 && high) begin nbusy = 1; ntime = 0; nsrc = 4; end
            m_ctl = nctl; m_thr = nthr; m_armed = narm; m_busy = nbusy; m_time = ntime; m_src = nsrc;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(pause_req) == m_busy, "R8 model pause_req", pause_req, m_busy);
            chk(int'(pause_time) == m_time, "R8 model pause_time", pause_time, m_time);
            chk(int'(ctl_rdata) == m_ctl, "R6 model ctl_rdata", ctl_rdata, m_ctl);
            chk(int'(thr_rdata) == m_thr, "R1 model thr_rdata", thr_rdata, m_thr);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [2:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_thr(input logic [7:0] v);
        @(negedge clk); thr_we = 1'b1; thr_wdata = v;
        @(negedge clk); thr_we = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic expect_req(input bit req, input int t, input string tag);
        chk(pause_req == req, tag, pause_req, req);
        if (req) chk(int'(pause_time) == t, tag, pause_time, t);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R5 reset state
        chk(thr_rdata == 8'h38, "R5 thr reset", thr_rdata, 'h38);
        chk(ctl_rdata == 3'b000, "R5 ctl reset", ctl_rdata, 0);
        chk(!pause_req, "R5 no request", pause_req, 0);

        // R7 auto off: low space raises nothing
        free_bytes = 16'd100; step(5);
        expect_req(0, 0, "R7 auto disabled");

        // R2 boundary: exactly 3072 free is not low
        free_bytes = 16'd3072; wr_ctl(3'b001); step(4);
        expect_req(0, 0, "R2 boundary equal");
        free_bytes = 16'd3071; step(2);
        expect_req(1, 'hFFFF, "R2 auto max");
        step(5);
        expect_req(1, 'hFFFF, "R8 held until done");
        done_pulse();
        expect_req(0, 0, "R8 drops after done");
        step(6);
        expect_req(0, 0, "R9 single max under sustained low");
        // R3 boundary: exactly 8192 does not resume
        free_bytes = 16'd8192; step(4);
        expect_req(0, 0, "R3 boundary equal");
        free_bytes = 16'd8193; step(2);
        expect_req(1, 0, "R3 resume");
        done_pulse(); step(4);
        expect_req(0, 0, "R3 resume sent once");

        // R4 zero high-water mark
        wr_thr(8'h08);
        chk(thr_rdata == 8'h08, "R1 thr write", thr_rdata, 'h08);
        free_bytes = 16'd1; step(4);
        expect_req(0, 0, "R4 one byte free");
        free_bytes = 16'd0; step(2);
        expect_req(1, 'hFFFF, "R4 zero free");
        done_pulse(); free_bytes = 16'd20000; step(2);
        expect_req(1, 0, "R4 resume");
        done_pulse(); step(2);
        wr_ctl(3'b000); wr_thr(8'h38); step(2);

        // R6 forced max with self-clear
        wr_ctl(3'b010); step(1);
        expect_req(1, 'hFFFF, "R6 force max");
        chk(ctl_rdata == 3'b010, "R6 bit readback", ctl_rdata, 2);
        done_pulse(); step(1);
        chk(ctl_rdata == 3'b000, "R6 self clear", ctl_rdata, 0);
        step(3);
        expect_req(0, 0, "R6 no repeat");

        // R10 both forces: max first, then zero
        wr_ctl(3'b110); step(1);
        expect_req(1, 'hFFFF, "R10 max first");
        done_pulse(); step(1);
        expect_req(1, 0, "R10 zero second");
        chk(ctl_rdata == 3'b100, "R10 zero bit pending", ctl_rdata, 4);
        done_pulse(); step(2);
        chk(ctl_rdata == 3'b000, "R10 both cleared", ctl_rdata, 0);

        // R11 force beats auto; forced frame does not arm (R3)
        free_bytes = 16'd500; wr_ctl(3'b101); step(1);
        expect_req(1, 0, "R11 forced zero first");
        done_pulse(); step(1);
        expect_req(1, 'hFFFF, "R11 auto max after force");
        done_pulse(); step(2);

        // R12 disabling auto drops the armed resume
        wr_ctl(3'b000); free_bytes = 16'd30000; step(2);
        wr_ctl(3'b001); step(6);
        expect_req(0, 0, "R12 no resume after disarm");
        wr_ctl(3'b000); step(2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule